// File: doc/BRIEF.md
# Row-Conflict Driven Promotion Filter for a Hybrid DRAM/PCM Memory

This unit sits beside the controller of a large phase-change main memory that is fronted by a small DRAM cache. It observes each access made to the phase-change memory, together with whether that access found its row already open in the row buffer. Only accesses that missed the open row are counted, because an open-row hit costs the same in either technology and so gains nothing from migration. The costly case is reopening a slow phase-change array row. A row that reopens repeatedly is worth moving into DRAM.

Per-row miss counts live in a small fully associative table with least-recently-used replacement. When a row's count reaches the active threshold, the unit emits a single-cycle migrate request naming the row and frees its table entry. Streaming traffic, which mostly hits the open row, never builds up a count and stays in phase-change memory. The threshold comes from a configuration input. In adaptive mode it is instead moved by one step at the end of every fixed-length epoch of accesses, according to how many promotions the epoch produced.

Top module: `row_place_unit`

## Requirements
- R1: After reset the table is empty, `mig_valid` is 0, and in static mode `thr_cur` equals the configured threshold.
- R2: An access flagged as a row-buffer hit never changes any miss count and never raises `mig_valid` in the following cycle.
- R3: Each row-buffer miss adds one to that row's count. The miss that brings the count up to the threshold raises `mig_valid` for exactly one cycle, in the cycle after the access, with `mig_row` equal to the row.
- R4: A promoted row's entry is cleared, so its next miss starts again from a count of one.
- R5: With a threshold of 1, every row-buffer miss is promoted at once.
- R6: The table holds `ENTRIES` rows (16 by default). A miss to an untracked row with the table full replaces the least recently missed row, and that row's count is lost.
- R7: A miss to a tracked row makes that row the most recently used.
- R8: In static mode (`dyn_en` = 0) the threshold follows `thr_cfg`, and a value of 0 is treated as 1.
- R9: In adaptive mode (`dyn_en` = 1), after every `EPOCH` accesses (1024 by default, hits and misses alike) the threshold rises by one if more than `MIG_LIMIT` promotions (default 4) happened in that epoch. It falls by one if none happened. It always stays between 1 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access to phase-change memory occurs this cycle |
| acc_row | input | ROW_W | Row address of the access |
| acc_hit | input | 1 | 1 = access hit the open row buffer, 0 = row-buffer miss |
| dyn_en | input | 1 | 1 = adaptive threshold, 0 = threshold from `thr_cfg` |
| thr_cfg | input | CNT_W | Configured promotion threshold |
| mig_valid | output | 1 | One-cycle request to migrate `mig_row` into DRAM |
| mig_row | output | ROW_W | Row to migrate |
| thr_cur | output | CNT_W | Threshold currently in force |

## Verification
The main function is driven with interleaved misses to two rows. This separates per-row counting from a shared count and shows that each count restarts after promotion. Runs of open-row hits mixed into the misses show that hits neither advance a count nor trigger a request. A streaming pattern of hits ending in a single miss shows that such rows stay put. Filling all sixteen entries and then touching one row again before adding a new one shows which row the replacement picks. Separate epochs of all hits and all promoting misses show that the adaptive threshold moves in both directions and stops at its lower bound.

// File: rtl/row_place_unit.sv
module row_place_unit #(
  parameter int ROW_W     = 16,
  parameter int ENTRIES   = 16,
  parameter int CNT_W     = 4,
  parameter int EPOCH     = 1024,
  parameter int MIG_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [ROW_W-1:0] acc_row,
  input  logic             acc_hit,
  input  logic             dyn_en,
  input  logic [CNT_W-1:0] thr_cfg,
  output logic             mig_valid,
  output logic [ROW_W-1:0] mig_row,
  output logic [CNT_W-1:0] thr_cur
);
  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int EW = (EPOCH > 1) ? $clog2(EPOCH) : 1;
  localparam int MW = $clog2(EPOCH + 1);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  logic [ROW_W-1:0] tag_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [AW-1:0]    age_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [CNT_W-1:0] thr_q;
  logic [EW-1:0]    ep_q;
  logic [MW-1:0]    mep_q;

  logic             match, free;
  logic [AW-1:0]    match_idx, free_idx, lru_idx, sel_idx;
  logic [CNT_W-1:0] cur_cnt, new_cnt;

  always_comb begin
    match = 1'b0; match_idx = '0;
    free = 1'b0;  free_idx = '0;
    lru_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && tag_q[i] == acc_row) begin
        match = 1'b1; match_idx = AW'(i);
      end
      if (!vld_q[i]) begin
        free = 1'b1; free_idx = AW'(i);
      end
      if (age_q[i] == AW'(ENTRIES - 1)) lru_idx = AW'(i);
    end
  end

  wire [CNT_W-1:0] cfg_eff = (thr_cfg == '0) ? CONE : thr_cfg;
  assign sel_idx = match ? match_idx : (free ? free_idx : lru_idx);
  assign cur_cnt = match ? cnt_q[match_idx] : '0;
  assign new_cnt = (cur_cnt == CMAX) ? CMAX : cur_cnt + CONE;

  wire miss_ev = acc_valid && !acc_hit;
  wire promote = miss_ev && (new_cnt >= thr_q);
  wire [AW-1:0] sel_age = age_q[sel_idx];
  wire [MW-1:0] mig_nx  = mep_q + MW'(promote);
  wire          ep_last = (ep_q == EW'(EPOCH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
        age_q[i] <= AW'(i);
      end
    end else if (miss_ev) begin
      if (promote) begin
        if (match) vld_q[match_idx] <= 1'b0;
      end else begin
        vld_q[sel_idx] <= 1'b1;
        tag_q[sel_idx] <= acc_row;
        cnt_q[sel_idx] <= new_cnt;
        for (int i = 0; i < ENTRIES; i++) begin
          if (AW'(i) == sel_idx)       age_q[i] <= '0;
          else if (age_q[i] < sel_age) age_q[i] <= age_q[i] + AW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mig_valid <= 1'b0;
      mig_row   <= '0;
    end else begin
      mig_valid <= promote;
      if (promote) mig_row <= acc_row;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !dyn_en) begin
      thr_q <= cfg_eff;
      ep_q  <= '0;
      mep_q <= '0;
    end else if (acc_valid) begin
      if (ep_last) begin
        ep_q  <= '0;
        mep_q <= '0;
        if (mig_nx > MW'(MIG_LIMIT) && thr_q != CMAX) thr_q <= thr_q + CONE;
        else if (mig_nx == '0 && thr_q > CONE)        thr_q <= thr_q - CONE;
      end else begin
        ep_q  <= ep_q + EW'(1);
        mep_q <= mig_nx;
      end
    end
  end

  assign thr_cur = thr_q;
endmodule

// File: rtl/row_place_chk.sv
module row_place_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_hit,
  input logic             dyn_en,
  input logic             mig_valid,
  input logic [CNT_W-1:0] thr_cur
);
  a_r3_req_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
    mig_valid |-> $past(acc_valid && !acc_hit));

  a_r2_hit_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_hit) |=> !mig_valid);

  a_r5_unit_thr_promotes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_hit && thr_cur == CNT_W'(1)) |=> mig_valid);

  a_r9_thr_floor: assert property (@(posedge clk) disable iff (!rst_n)
    thr_cur != '0);

  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_en && $past(dyn_en)) |->
      (thr_cur == $past(thr_cur) || thr_cur == $past(thr_cur) + CNT_W'(1) ||
       thr_cur == $past(thr_cur) - CNT_W'(1)));
endmodule

bind row_place_unit row_place_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
  .dyn_en(dyn_en), .mig_valid(mig_valid), .thr_cur(thr_cur)
);

// File: tb/row_place_unit_test.sv
module row_place_unit_test;
  localparam int ROW_W = 16;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [ROW_W-1:0] acc_row = '0;
  logic acc_hit = 1'b0;
  logic dyn_en = 1'b0;
  logic [3:0] thr_cfg = 4'd3;
  logic mig_valid;
  logic [ROW_W-1:0] mig_row;
  logic [3:0] thr_cur;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  row_place_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_row(acc_row),
    .acc_hit(acc_hit), .dyn_en(dyn_en), .thr_cfg(thr_cfg),
    .mig_valid(mig_valid), .mig_row(mig_row), .thr_cur(thr_cur)
  );

  // {hit, expected migrate, row}; threshold 3
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0010}, {1'b0, 1'b0, 16'h0010},
    {1'b1, 1'b0, 16'h0010}, {1'b1, 1'b0, 16'h0010},
    {1'b0, 1'b1, 16'h0010}, {1'b0, 1'b0, 16'h0010},
    {1'b0, 1'b0, 16'h0020}, {1'b0, 1'b0, 16'h0020},
    {1'b0, 1'b0, 16'h0010}, {1'b0, 1'b1, 16'h0020},
    {1'b0, 1'b1, 16'h0010}, {1'b1, 1'b0, 16'h0030},
    {1'b1, 1'b0, 16'h0030}, {1'b1, 1'b0, 16'h0030},
    {1'b1, 1'b0, 16'h0030}, {1'b0, 1'b0, 16'h0030}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic hit, input logic [ROW_W-1:0] row);
    acc_valid = 1'b1; acc_hit = hit; acc_row = row;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic access_chk(input logic hit, input logic [ROW_W-1:0] row,
                            input logic exp, input string req);
    access(hit, row);
    check(mig_valid == exp, req, int'(mig_valid), int'(exp));
    if (exp) check(mig_row == row, req, int'(mig_row), int'(row));
  endtask

  task automatic do_reset(input logic [3:0] cfg);
    thr_cfg = cfg; dyn_en = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(4'd3);
    check(mig_valid == 1'b0, "R1 reset mig_valid", int'(mig_valid), 0);
    check(thr_cur == 4'd3, "R1 reset threshold", int'(thr_cur), 3);

    // R2 R3 R4 table walk
    for (int i = 0; i < NV; i++)
      access_chk(VEC[i][17], VEC[i][15:0], VEC[i][16], "R3/R2/R4 vector");

    // one-cycle pulse: idle cycle afterwards
    access_chk(1'b0, 16'h0040, 1'b0, "R3 fresh row");
    access_chk(1'b0, 16'h0040, 1'b0, "R3 second miss");
    access_chk(1'b0, 16'h0040, 1'b1, "R3 third miss");
    @(negedge clk);
    check(mig_valid == 1'b0, "R3 single-cycle pulse", int'(mig_valid), 0);

    // R6 R7 replacement
    do_reset(4'd3);
    for (int k = 0; k < 16; k++) access_chk(1'b0, 16'h0100 + 16'(k), 1'b0, "R6 fill");
    access_chk(1'b0, 16'h0100, 1'b0, "R7 refresh oldest");
    access_chk(1'b0, 16'h0200, 1'b0, "R6 allocate over LRU");
    access_chk(1'b0, 16'h0101, 1'b0, "R6 evicted row restarts");
    access_chk(1'b0, 16'h0101, 1'b0, "R6 evicted row count lost");
    access_chk(1'b0, 16'h0100, 1'b1, "R7 refreshed row kept");
    access_chk(1'b0, 16'h0101, 1'b1, "R6 rebuilt count promotes");

    // R5 R8
    do_reset(4'd0);
    check(thr_cur == 4'd1, "R8 zero treated as one", int'(thr_cur), 1);
    access_chk(1'b0, 16'h0555, 1'b1, "R5 immediate promotion");
    access_chk(1'b1, 16'h0555, 1'b0, "R5 hit still ignored");
    thr_cfg = 4'd7;
    @(negedge clk);
    check(thr_cur == 4'd7, "R8 static follows config", int'(thr_cur), 7);

    // R9 adaptive
    do_reset(4'd2);
    dyn_en = 1'b1;
    thr_cfg = 4'd9;
    for (int k = 0; k < 1023; k++) access(1'b1, 16'h0007);
    check(thr_cur == 4'd2, "R9 no change mid-epoch", int'(thr_cur), 2);
    access(1'b1, 16'h0007);
    check(thr_cur == 4'd1, "R9 quiet epoch lowers", int'(thr_cur), 1);
    for (int k = 0; k < 1024; k++) access(1'b0, 16'(k));
    check(thr_cur == 4'd2, "R9 busy epoch raises", int'(thr_cur), 2);
    for (int k = 0; k < 1024; k++) access(1'b1, 16'h0009);
    check(thr_cur == 4'd1, "R9 lowers again", int'(thr_cur), 1);
    for (int k = 0; k < 1024; k++) access(1'b1, 16'h0009);
    check(thr_cur == 4'd1, "R9 floor at one", int'(thr_cur), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule